// File: doc/BRIEF.md
# Trace Lookahead Object Predictor

This block watches a stream of object identifiers and learns, for each object it has seen, the order of the objects that followed that object the last time it was fully observed. When the object turns up again, the block offers one prediction for each lookahead distance 1 to N. Each prediction is the object that stood at that same position after the earlier occurrence. No address arithmetic is involved. The predictions come early enough for a prefetcher to start fetching several accesses ahead.

Recording uses a short history of the last N accesses. Once an object has been followed by N further accesses, its entry in a direct-mapped, fully tagged table is overwritten with those N followers. Every prediction that is issued is held in a per-distance scoreboard. When the access at that distance arrives, the prediction is scored: the per-distance total counter always increments, and the hit counter increments when the prediction matches. Software can read these counters to judge accuracy at each distance.

Top module: `trace_lookahead_pred`

## Requirements
- R1: After reset, every pred_valid_o bit is 0, all hit and total counters are 0, the table is empty and the history is empty.
- R2: An access to an object with no stored record gives pred_valid_o all 0 in the following cycle.
- R3: The table lookup uses the table as it stood before the access. An access to an object with a stored record sets all pred_valid_o bits in the following cycle. Slot i, held in pred_id_o[i*ID_W +: ID_W], carries the object that came i+1 accesses after the recorded occurrence. Slot 0 is therefore the immediate successor.
- R4: An occurrence of an object is recorded only on the access that arrives N accesses after it. Until then, a lookup of that object still returns its earlier record, or no record at all.
- R5: A new record for an object replaces all N slots of its previous record.
- R6: The table entry is selected by the low log2(ENTRIES) bits of the identifier, and the full identifier is stored as the tag. A newer record for another object with the same index evicts the older one. A lookup whose tag does not match predicts nothing.
- R7: A prediction issued for distance d is scored on the d-th access after it. tot_cnt_o slice d-1 increments by 1, and hit_cnt_o slice d-1 also increments when the identifier of that access equals the prediction. Counter slice d-1 is at bits [(d-1)*CNT_W +: CNT_W].
- R8: A cycle with acc_valid_i low issues no prediction and leaves the history, the scoreboard and the counters unchanged.
- R9: NSTRIDE is restricted to 1 through 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | An access is present this cycle |
| acc_id_i | input | ID_W | Object identifier of the access |
| pred_valid_o | output | NSTRIDE | Per-distance prediction valid, bit i for distance i+1 |
| pred_id_o | output | NSTRIDE*ID_W | Predicted identifiers, slot i for distance i+1 |
| hit_cnt_o | output | NSTRIDE*CNT_W | Per-distance correct-prediction counters |
| tot_cnt_o | output | NSTRIDE*CNT_W | Per-distance scored-prediction counters |

## Verification
A corrupted table entry or a misaligned history stage appears one cycle after the next access to that object, as a wrong slot identifier or a missing valid bit. A slot shifted by one position shows up as the successor of the wrong distance. A scoreboard that is off by one stage gets its prediction scored at the wrong access. That error shows in hit_cnt_o within d accesses for distance d, and tot_cnt_o goes wrong during warm-up. The reference model compares every output on every clock, so each of these faults is caught on the first affected cycle.

// File: rtl/trace_pred_pkg.sv
package trace_pred_pkg;
  localparam int unsigned MAX_STRIDE = 5;

  function automatic int unsigned idx_bits(input int unsigned n);
    int unsigned b;
    b = 1;
    while ((1 << b) < n) b++;
    return b;
  endfunction
endpackage

// File: rtl/tp_hist.sv
module tp_hist #(
  parameter int unsigned ID_W    = 8,
  parameter int unsigned NSTRIDE = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [ID_W-1:0] id_i,
  output logic [ID_W-1:0] hist_id_o [NSTRIDE],
  output logic [NSTRIDE-1:0] hist_v_o
);
  logic [ID_W-1:0]    id_q [NSTRIDE];
  logic [NSTRIDE-1:0] v_q;

  // stage 0 holds the newest access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int s = 0; s < NSTRIDE; s++) id_q[s] <= '0;
    end else if (push_i) begin
      v_q[0]  <= 1'b1;
      id_q[0] <= id_i;
      for (int s = 1; s < NSTRIDE; s++) begin
        v_q[s]  <= v_q[s-1];
        id_q[s] <= id_q[s-1];
      end
    end
  end

  assign hist_id_o = id_q;
  assign hist_v_o  = v_q;
endmodule

// File: rtl/tp_table.sv
module tp_table #(
  parameter int unsigned ID_W    = 8,
  parameter int unsigned NSTRIDE = 4,
  parameter int unsigned ENTRIES = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ID_W-1:0]         rd_id_i,
  output logic                    rd_hit_o,
  output logic [NSTRIDE*ID_W-1:0] rd_slots_o,
  input  logic                    wr_en_i,
  input  logic [ID_W-1:0]         wr_id_i,
  input  logic [NSTRIDE*ID_W-1:0] wr_slots_i
);
  localparam int unsigned IDX_W = trace_pred_pkg::idx_bits(ENTRIES);

  logic [ENTRIES-1:0]      v_q;
  logic [ID_W-1:0]         tag_q  [ENTRIES];
  logic [NSTRIDE*ID_W-1:0] slot_q [ENTRIES];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  assign rd_idx = rd_id_i[IDX_W-1:0];
  assign wr_idx = wr_id_i[IDX_W-1:0];

  assign rd_hit_o   = v_q[rd_idx] && (tag_q[rd_idx] == rd_id_i);
  assign rd_slots_o = slot_q[rd_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      v_q <= '0;
    else if (wr_en_i) v_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx]  <= wr_id_i;
      slot_q[wr_idx] <= wr_slots_i;
    end
  end
endmodule

// File: rtl/tp_score.sv
module tp_score #(
  parameter int unsigned ID_W    = 8,
  parameter int unsigned NSTRIDE = 4,
  parameter int unsigned CNT_W   = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     acc_valid_i,
  input  logic [ID_W-1:0]          acc_id_i,
  input  logic                     pred_v_i,
  input  logic [NSTRIDE*ID_W-1:0]  pred_id_i,
  output logic [NSTRIDE*CNT_W-1:0] hit_cnt_o,
  output logic [NSTRIDE*CNT_W-1:0] tot_cnt_o
);
  for (genvar d = 0; d < NSTRIDE; d++) begin : g_dist
    localparam int unsigned DEPTH = d + 1;
    logic [DEPTH-1:0] v_q;
    logic [ID_W-1:0]  id_q [DEPTH];
    logic [CNT_W-1:0] hit_q, tot_q;
    logic             due, match;

    // oldest stage holds the prediction made DEPTH accesses ago
    assign due   = acc_valid_i && v_q[DEPTH-1];
    assign match = id_q[DEPTH-1] == acc_id_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q   <= '0;
        hit_q <= '0;
        tot_q <= '0;
        for (int s = 0; s < DEPTH; s++) id_q[s] <= '0;
      end else if (acc_valid_i) begin
        if (due) begin
          tot_q <= tot_q + 1'b1;
          if (match) hit_q <= hit_q + 1'b1;
        end
        for (int s = DEPTH - 1; s >= 1; s--) begin
          v_q[s]  <= v_q[s-1];
          id_q[s] <= id_q[s-1];
        end
        v_q[0]  <= pred_v_i;
        id_q[0] <= pred_id_i[d*ID_W +: ID_W];
      end
    end

    assign hit_cnt_o[d*CNT_W +: CNT_W] = hit_q;
    assign tot_cnt_o[d*CNT_W +: CNT_W] = tot_q;
  end
endmodule

// File: rtl/trace_lookahead_pred.sv
module trace_lookahead_pred #(
  parameter int unsigned ID_W    = 8,
  parameter int unsigned NSTRIDE = 4,
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned CNT_W   = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     acc_valid_i,
  input  logic [ID_W-1:0]          acc_id_i,
  output logic [NSTRIDE-1:0]       pred_valid_o,
  output logic [NSTRIDE*ID_W-1:0]  pred_id_o,
  output logic [NSTRIDE*CNT_W-1:0] hit_cnt_o,
  output logic [NSTRIDE*CNT_W-1:0] tot_cnt_o
);
  localparam int unsigned IDX_W = trace_pred_pkg::idx_bits(ENTRIES);

  // R9: lookahead limit
  if (NSTRIDE < 1 || NSTRIDE > trace_pred_pkg::MAX_STRIDE) begin : g_bad_stride
    $error("NSTRIDE out of range");
  end
  if (ID_W < IDX_W) begin : g_bad_id
    $error("ID_W narrower than index");
  end

  logic [ID_W-1:0]         hist_id [NSTRIDE];
  logic [NSTRIDE-1:0]      hist_v;
  logic                    rd_hit;
  logic [NSTRIDE*ID_W-1:0] rd_slots;
  logic                    wr_en;
  logic [NSTRIDE*ID_W-1:0] wr_slots;
  logic                    look_v;

  tp_hist #(.ID_W(ID_W), .NSTRIDE(NSTRIDE)) u_hist (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (acc_valid_i),
    .id_i      (acc_id_i),
    .hist_id_o (hist_id),
    .hist_v_o  (hist_v)
  );

  // record the oldest history object with the N accesses that followed it
  assign wr_en = acc_valid_i && hist_v[NSTRIDE-1];

  for (genvar j = 0; j < NSTRIDE; j++) begin : g_wslot
    if (j == NSTRIDE - 1) begin : g_last
      assign wr_slots[j*ID_W +: ID_W] = acc_id_i;
    end else begin : g_hist
      assign wr_slots[j*ID_W +: ID_W] = hist_id[NSTRIDE-2-j];
    end
  end

  tp_table #(.ID_W(ID_W), .NSTRIDE(NSTRIDE), .ENTRIES(ENTRIES)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_id_i    (acc_id_i),
    .rd_hit_o   (rd_hit),
    .rd_slots_o (rd_slots),
    .wr_en_i    (wr_en),
    .wr_id_i    (hist_id[NSTRIDE-1]),
    .wr_slots_i (wr_slots)
  );

  assign look_v = acc_valid_i && rd_hit;

  tp_score #(.ID_W(ID_W), .NSTRIDE(NSTRIDE), .CNT_W(CNT_W)) u_score (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_valid_i (acc_valid_i),
    .acc_id_i    (acc_id_i),
    .pred_v_i    (look_v),
    .pred_id_i   (rd_slots),
    .hit_cnt_o   (hit_cnt_o),
    .tot_cnt_o   (tot_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_o <= '0;
      pred_id_o    <= '0;
    end else begin
      pred_valid_o <= {NSTRIDE{look_v}};
      if (look_v) pred_id_o <= rd_slots;
    end
  end
endmodule

// File: rtl/trace_lookahead_pred_chk.sv
module trace_lookahead_pred_chk #(
  parameter int unsigned ID_W    = 8,
  parameter int unsigned NSTRIDE = 4,
  parameter int unsigned CNT_W   = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     acc_valid_i,
  input logic [ID_W-1:0]          acc_id_i,
  input logic [NSTRIDE-1:0]       pred_valid_o,
  input logic [NSTRIDE*ID_W-1:0]  pred_id_o,
  input logic [NSTRIDE*CNT_W-1:0] hit_cnt_o,
  input logic [NSTRIDE*CNT_W-1:0] tot_cnt_o
);
  AST_IDLE_NO_PRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> pred_valid_o == '0); // R8

  AST_IDLE_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> ($stable(tot_cnt_o) && $stable(hit_cnt_o))); // R8

  AST_SLOTS_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_valid_o == '0) || (&pred_valid_o)); // R3

  for (genvar d = 0; d < NSTRIDE; d++) begin : g_d
    AST_HIT_LE_TOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_cnt_o[d*CNT_W +: CNT_W] <= tot_cnt_o[d*CNT_W +: CNT_W]); // R7

    AST_TOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_valid_i |=> (CNT_W'(tot_cnt_o[d*CNT_W +: CNT_W]
                             - $past(tot_cnt_o[d*CNT_W +: CNT_W])) <= CNT_W'(1))); // R7
  end
endmodule

bind trace_lookahead_pred trace_lookahead_pred_chk #(
  .ID_W(ID_W), .NSTRIDE(NSTRIDE), .CNT_W(CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .acc_valid_i  (acc_valid_i),
  .acc_id_i     (acc_id_i),
  .pred_valid_o (pred_valid_o),
  .pred_id_o    (pred_id_o),
  .hit_cnt_o    (hit_cnt_o),
  .tot_cnt_o    (tot_cnt_o)
);

// File: tb/trace_lookahead_pred_tb.sv
module trace_lookahead_pred_tb;
  localparam int ID_W = 8;
  localparam int NS   = 4;
  localparam int ENT  = 32;
  localparam int CW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [ID_W-1:0] acc_id = '0;
  logic [NS-1:0] pred_valid;
  logic [NS*ID_W-1:0] pred_id;
  logic [NS*CW-1:0] hit_cnt, tot_cnt;

  always #2 clk = ~clk;

  trace_lookahead_pred #(.ID_W(ID_W), .NSTRIDE(NS), .ENTRIES(ENT), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_id_i(acc_id),
    .pred_valid_o(pred_valid), .pred_id_o(pred_id),
    .hit_cnt_o(hit_cnt), .tot_cnt_o(tot_cnt)
  );

  int errors = 0;
  int checks = 0;

  // reference model
  bit m_v [ENT];
  int m_tag [ENT];
  int m_sl [ENT][NS];
  int hq[$];
  int sb [NS][$];
  int m_hit [NS];
  int m_tot [NS];
  bit e_v;
  int e_id [NS];

  task automatic check(bit ok, string rq, string what, int got, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, got, exp);
    end
  endtask

  task automatic model(bit v, int id);
    int idx, old;
    e_v = 1'b0;
    if (!v) return;
    idx = id % ENT;
    if (m_v[idx] && m_tag[idx] == id) begin
      e_v = 1'b1;
      for (int j = 0; j < NS; j++) e_id[j] = m_sl[idx][j];
    end
    for (int d = 0; d < NS; d++) begin
      if (sb[d].size() == d + 1) begin
        old = sb[d].pop_back();
        if (old >= 0) begin
          m_tot[d]++;
          if (old == id) m_hit[d]++;
        end
      end
      sb[d].push_front(e_v ? e_id[d] : -1);
    end
    if (hq.size() == NS) begin
      old = hq[NS-1];
      m_v[old % ENT] = 1'b1;
      m_tag[old % ENT] = old;
      for (int j = 0; j < NS; j++) m_sl[old % ENT][j] = (j < NS - 1) ? hq[NS-2-j] : id;
    end
    hq.push_front(id);
    if (hq.size() > NS) void'(hq.pop_back());
  endtask

  task automatic compare(string rq);
    for (int j = 0; j < NS; j++) begin
      check(pred_valid[j] == e_v, rq, $sformatf("pred_valid[%0d]", j), pred_valid[j], e_v);
      if (e_v)
        check(pred_id[j*ID_W +: ID_W] == e_id[j], rq, $sformatf("pred_id[%0d]", j),
              pred_id[j*ID_W +: ID_W], e_id[j]);
      check(hit_cnt[j*CW +: CW] == m_hit[j], "R7", $sformatf("hit_cnt[%0d]", j),
            hit_cnt[j*CW +: CW], m_hit[j]);
      check(tot_cnt[j*CW +: CW] == m_tot[j], "R7", $sformatf("tot_cnt[%0d]", j),
            tot_cnt[j*CW +: CW], m_tot[j]);
    end
  endtask

  task automatic step(bit v, int id, string rq);
    @(negedge clk);
    acc_valid = v;
    acc_id = ID_W'(id);
    @(posedge clk);
    model(v, id);
    #1;
    compare(rq);
  endtask

  // expect a specific prediction vector from the requirement itself
  task automatic expect_pred(bit v, int a, int b, int c, int d, string rq);
    int ex [NS];
    ex = '{a, b, c, d};
    check(pred_valid == {NS{v}}, rq, "direct pred_valid", int'(pred_valid), v ? 15 : 0);
    if (v)
      for (int j = 0; j < NS; j++)
        check(pred_id[j*ID_W +: ID_W] == ex[j], rq, $sformatf("direct slot %0d", j),
              pred_id[j*ID_W +: ID_W], ex[j]);
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int d = 0; d < NS; d++) begin m_hit[d] = 0; m_tot[d] = 0; end
    for (int i = 0; i < ENT; i++) m_v[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(pred_valid == '0, "R1", "reset pred_valid", int'(pred_valid), 0);
    check(hit_cnt == '0 && tot_cnt == '0, "R1", "reset counters", 0, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: unknown objects
    step(1, 8'h55, "R2");
    expect_pred(0, 0, 0, 0, 0, "R2");

    // R3: basic trace 1..8 then revisit 1
    for (int i = 1; i <= 8; i++) step(1, i, "R3");
    step(1, 1, "R3");
    expect_pred(1, 2, 3, 4, 5, "R3");
    // R8: idle cycles in between
    step(0, 0, "R8");
    step(0, 3, "R8");
    expect_pred(0, 0, 0, 0, 0, "R8");
    step(1, 2, "R3");
    expect_pred(1, 3, 4, 5, 6, "R3");

    // R4: object revisited before N followers seen
    step(1, 8'h40, "R4");
    step(1, 8'h41, "R4");
    step(1, 8'h40, "R4");
    expect_pred(0, 0, 0, 0, 0, "R4");

    // R5: rerecord object 1 with new followers
    step(1, 1, "R5");
    for (int i = 9; i <= 12; i++) step(1, i, "R5");
    step(1, 13, "R5");
    step(1, 1, "R5");
    expect_pred(1, 9, 10, 11, 12, "R5");

    // R6: 0x21 shares index with 0x01 and evicts it
    step(1, 8'h21, "R6");
    for (int i = 20; i <= 24; i++) step(1, i, "R6");
    step(1, 1, "R6");
    expect_pred(0, 0, 0, 0, 0, "R6");
    step(1, 8'h21, "R6");
    expect_pred(1, 20, 21, 22, 23, "R6");

    // repeated loop to drive hit counting, then random mix
    for (int r = 0; r < 6; r++)
      for (int i = 0; i < 7; i++) step(1, 8'h60 + i, "R7");
    for (int k = 0; k < 400; k++)
      step(($urandom_range(0, 4) != 0), $urandom_range(0, 47), "R3");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule